// File: doc/BRIEF.md
# Interrupt-Aware In-Order Retirement for a Micro-op Reorder Buffer

This unit sits at the back of an out-of-order core. Rename writes micro-ops into a small circular reorder buffer. Each micro-op carries markers for the first and the last micro-op of its instruction, a device-access flag and the PC of its instruction. Execution units report completion by buffer index. The unit retires finished micro-ops from the oldest end in program order, at most two per cycle.

An asynchronous interrupt request is accepted only between two whole instructions. If an instruction has started to retire, its remaining micro-ops must finish and retire before the interrupt is taken. When the interrupt is taken, the unit raises a one-cycle flush that discards every un-retired entry. The acknowledge rises in the same cycle, and the flush carries the PC at which execution must restart.

Memory micro-ops whose memory type is uncacheable may start their access only when they are the oldest entry. The unit grants that start. From the grant until the micro-op retires, interrupt recognition is held off, so the device access is never repeated.

Top module: `rob_irq_retire`

## Requirements
- R1: `alloc_ready` is low while the buffer holds DEPTH entries. Each accepted allocation returns `alloc_tag` equal to the previous tag plus one, modulo DEPTH.
- R2: Retirement follows program order. Each cycle `retire_cnt` (0, 1 or 2) micro-ops retire, counted from the oldest entry `ret_tag`. Retirement stops at the first entry that is not done, even if younger entries are done.
- R3: While an instruction is partly retired (a micro-op without the last marker was the youngest to retire), `irq_ack` stays low even if `irq_req` is high.
- R4: The remaining micro-ops of a partly retired instruction retire first. The interrupt is then taken in the first cycle in which the oldest entry starts a new instruction.
- R5: Taking an interrupt raises `flush` and `irq_ack` together for one cycle. `flush_pc` is the PC of the oldest un-retired entry.
- R6: On and after a flush, every discarded entry is gone. `retire_cnt` is 0 in the flush cycle and the cycle after it. A completion that names a discarded index causes no retirement. `alloc_ready` is high again, and the next tag is the index of the oldest discarded entry.
- R7: `uc_grant` pulses for exactly one cycle, only when an uncacheable entry is the oldest entry. `uc_grant_tag` gives that entry's index. There is no grant while an older entry is still present.
- R8: From an uncacheable grant until that micro-op retires, `irq_ack` stays low.
- R9: With the buffer empty and `irq_req` high, the interrupt is taken in that cycle, and `flush_pc` equals `front_pc`.
- R10: After reset the buffer is empty: `alloc_ready`=1, `alloc_tag`=0, and `retire_cnt`, `irq_ack`, `flush` and `uc_grant` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Rename offers a micro-op |
| alloc_first | input | 1 | Micro-op is the first of its instruction |
| alloc_last | input | 1 | Micro-op is the last of its instruction |
| alloc_uc | input | 1 | Memory micro-op with uncacheable memory type |
| alloc_pc | input | PC_W | PC of the owning instruction |
| alloc_ready | output | 1 | Offer is accepted this cycle |
| alloc_tag | output | IDX_W | Index given to the accepted micro-op |
| wb_valid | input | 1 | Completion report |
| wb_tag | input | IDX_W | Index of the completed micro-op |
| uc_grant | output | 1 | Uncacheable access at the head may start |
| uc_grant_tag | output | IDX_W | Index of the granted entry |
| retire_cnt | output | 2 | Micro-ops retiring this cycle |
| ret_tag | output | IDX_W | Index of the oldest entry |
| irq_req | input | 1 | Asynchronous interrupt pending |
| irq_ack | output | 1 | Interrupt taken this cycle |
| front_pc | input | PC_W | Next fetch PC, used as restart address when empty |
| flush | output | 1 | Discard all un-retired entries |
| flush_pc | output | PC_W | Restart address |

## Verification
The bound checker covers the properties that hold on every cycle. It checks the occupancy limit against allocation. It checks that retirement is quiet on and after a flush and that the device grant is a single pulse. It keeps small reference models of "instruction partly retired" and "device access in flight" and requires the acknowledge to stay low while either is set. Only the bench's scenarios show a set of other behaviours: the exact restart address, the retirement order when completions arrive out of order, the delayed acceptance once a split instruction finishes, and the tag numbering after a flush. Those need a known instruction stream and a scoreboard of expected retirements and flushes.

// File: rtl/rob_irq_pkg.sv
// Package: shared entry flag type for the interrupt-aware retirement unit.
// Assumes: the PC is stored beside the flags because its width is a parameter.
package rob_irq_pkg;
    typedef struct packed {
        logic valid;    // entry holds a live micro-op
        logic done;     // execution reported completion
        logic first;    // first micro-op of its instruction
        logic last;     // last micro-op of its instruction
        logic uc;       // uncacheable memory access
        logic started;  // uncacheable access has been granted
    } rob_flags_t;
endpackage

// File: rtl/rob_entry_store.sv
// Module: circular entry storage with head/tail pointers carrying a wrap bit.
// Assumes: DEPTH is a power of two; allocation is never requested when full;
// on flush no retirement happens in the same cycle.
module rob_entry_store
    import rob_irq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PC_W  = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_en,
    input  logic             alloc_first,
    input  logic             alloc_last,
    input  logic             alloc_uc,
    input  logic [PC_W-1:0]  alloc_pc,
    input  logic             wb_en,
    input  logic [IDX_W-1:0] wb_idx,
    input  logic             start_en,
    input  logic [1:0]       ret_cnt,
    input  logic             flush,
    output rob_flags_t       h0_flags,
    output rob_flags_t       h1_flags,
    output logic [PC_W-1:0]  h0_pc,
    output logic [IDX_W-1:0] head_idx,
    output logic [IDX_W-1:0] tail_idx,
    output logic [PTR_W-1:0] occ,
    output logic             full,
    output logic             empty
);
    rob_flags_t            flags_q [DEPTH];
    logic [PC_W-1:0]       pc_q    [DEPTH];
    logic [PTR_W-1:0]      head_q, tail_q;
    logic [IDX_W-1:0]      h1_idx;

    assign head_idx = head_q[IDX_W-1:0];
    assign tail_idx = tail_q[IDX_W-1:0];
    assign h1_idx   = IDX_W'(head_idx + 1'b1);
    assign occ      = tail_q - head_q;
    assign full     = (occ == PTR_W'(DEPTH));
    assign empty    = (occ == '0);
    assign h0_flags = flags_q[head_idx];
    assign h1_flags = flags_q[h1_idx];
    assign h0_pc    = pc_q[head_idx];

    // Advance head by retired count; tail by allocation, or snap to head on flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            head_q <= head_q + PTR_W'(ret_cnt);
            if (flush)         tail_q <= head_q;
            else if (alloc_en) tail_q <= tail_q + 1'b1;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        // Per-entry lifecycle: allocate, complete, start device access, retire, flush.
        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                flags_q[g] <= '0;
            end else begin
                if (alloc_en && tail_idx == IDX_W'(g)) begin
                    flags_q[g] <= '{valid: 1'b1, done: 1'b0, first: alloc_first,
                                    last: alloc_last, uc: alloc_uc, started: 1'b0};
                end
                if (wb_en && wb_idx == IDX_W'(g) && flags_q[g].valid)
                    flags_q[g].done <= 1'b1;
                if (start_en && head_idx == IDX_W'(g))
                    flags_q[g].started <= 1'b1;
                if ((ret_cnt != 2'd0 && head_idx == IDX_W'(g)) ||
                    (ret_cnt == 2'd2 && h1_idx == IDX_W'(g)))
                    flags_q[g].valid <= 1'b0;
            end
        end

        // Capture the instruction PC on allocation.
        always_ff @(posedge clk) begin
            if (!rst_n)                                   pc_q[g] <= '0;
            else if (alloc_en && tail_idx == IDX_W'(g))   pc_q[g] <= alloc_pc;
        end
    end
endmodule

// File: rtl/rob_retire_sel.sv
// Module: picks how many of the two oldest entries retire this cycle.
// Assumes: in-order; retirement stops at the first entry that is not done.
module rob_retire_sel
    import rob_irq_pkg::*;
(
    input  rob_flags_t h0_flags,
    input  rob_flags_t h1_flags,
    input  logic       block,
    output logic [1:0] ret_cnt,
    output logic       ret_last
);
    logic r0, r1;

    // Two-wide in-order selection from the head.
    always_comb begin
        r0       = h0_flags.valid && h0_flags.done && !block;
        r1       = r0 && h1_flags.valid && h1_flags.done;
        ret_cnt  = r1 ? 2'd2 : (r0 ? 2'd1 : 2'd0);
        ret_last = r1 ? h1_flags.last : h0_flags.last;
    end
endmodule

// File: rtl/rob_irq_gate.sv
// Module: decides when a pending interrupt is taken.
// Assumes: taken only when no instruction is partly retired, no device access is
// in flight, and the head begins an instruction (or the buffer is empty).
module rob_irq_gate
    import rob_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       irq_req,
    input  logic       empty,
    input  rob_flags_t h0_flags,
    input  logic [1:0] ret_cnt,
    input  logic       ret_last,
    output logic       take
);
    logic mid_q;
    logic dev_busy;
    logic boundary;

    // Combinational recognition from the start-of-cycle state.
    always_comb begin
        dev_busy = h0_flags.valid && h0_flags.started;
        boundary = empty || (h0_flags.valid && h0_flags.first);
        take     = irq_req && !mid_q && !dev_busy && boundary;
    end

    // Track whether the youngest retired micro-op left its instruction open.
    always_ff @(posedge clk) begin
        if (!rst_n || take)        mid_q <= 1'b0;
        else if (ret_cnt != 2'd0)  mid_q <= !ret_last;
    end
endmodule

// File: rtl/rob_irq_retire.sv
// Module: top of the interrupt-aware retirement unit; joins storage, retire
// selection and interrupt gating, and grants uncacheable accesses at the head.
// Assumes: one completion per cycle; interrupt source drops its request after ack.
module rob_irq_retire
    import rob_irq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PC_W  = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_valid,
    input  logic             alloc_first,
    input  logic             alloc_last,
    input  logic             alloc_uc,
    input  logic [PC_W-1:0]  alloc_pc,
    output logic             alloc_ready,
    output logic [IDX_W-1:0] alloc_tag,
    input  logic             wb_valid,
    input  logic [IDX_W-1:0] wb_tag,
    output logic             uc_grant,
    output logic [IDX_W-1:0] uc_grant_tag,
    output logic [1:0]       retire_cnt,
    output logic [IDX_W-1:0] ret_tag,
    input  logic             irq_req,
    output logic             irq_ack,
    input  logic [PC_W-1:0]  front_pc,
    output logic             flush,
    output logic [PC_W-1:0]  flush_pc
);
    rob_flags_t       h0_flags, h1_flags;
    logic [PC_W-1:0]  h0_pc;
    logic [IDX_W-1:0] head_idx, tail_idx;
    logic [PTR_W-1:0] occ;
    logic             full, empty, take, ret_last, alloc_en;

    // Edge handshakes and outputs, all masked by the flush decision.
    always_comb begin
        alloc_ready  = !full && !take;
        alloc_en     = alloc_valid && alloc_ready;
        alloc_tag    = tail_idx;
        uc_grant     = h0_flags.valid && h0_flags.uc && !h0_flags.started && !take;
        uc_grant_tag = head_idx;
        ret_tag      = head_idx;
        irq_ack      = take;
        flush        = take;
        flush_pc     = empty ? front_pc : h0_pc;
    end

    rob_entry_store #(.DEPTH(DEPTH), .PC_W(PC_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .alloc_en(alloc_en), .alloc_first(alloc_first), .alloc_last(alloc_last),
        .alloc_uc(alloc_uc), .alloc_pc(alloc_pc),
        .wb_en(wb_valid && !take), .wb_idx(wb_tag),
        .start_en(uc_grant), .ret_cnt(retire_cnt), .flush(take),
        .h0_flags(h0_flags), .h1_flags(h1_flags), .h0_pc(h0_pc),
        .head_idx(head_idx), .tail_idx(tail_idx), .occ(occ),
        .full(full), .empty(empty)
    );

    rob_retire_sel u_sel (
        .h0_flags(h0_flags), .h1_flags(h1_flags), .block(take),
        .ret_cnt(retire_cnt), .ret_last(ret_last)
    );

    rob_irq_gate u_gate (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .empty(empty),
        .h0_flags(h0_flags), .ret_cnt(retire_cnt), .ret_last(ret_last),
        .take(take)
    );
endmodule

// File: rtl/rob_irq_retire_chk.sv
// Module: assertion checker bound to the retirement unit.
// Assumes: observes ports plus occupancy and the last-marker of retired micro-ops.
module rob_irq_retire_chk #(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PTR_W-1:0] occ,
    input logic             alloc_ready,
    input logic [1:0]       retire_cnt,
    input logic             ret_last,
    input logic             flush,
    input logic             irq_ack,
    input logic             uc_grant
);
    logic mid_m;
    logic dev_m;

    // Reference model: an instruction is open after retiring a non-last micro-op.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)           mid_m <= 1'b0;
        else if (retire_cnt != 2'd0)   mid_m <= !ret_last;
    end

    // Reference model: device access in flight from grant until a retirement.
    always_ff @(posedge clk) begin
        if (!rst_n)                    dev_m <= 1'b0;
        else if (uc_grant)             dev_m <= 1'b1;
        else if (retire_cnt != 2'd0)   dev_m <= 1'b0;
    end

    p_no_alloc_when_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == PTR_W'(DEPTH)) |-> !alloc_ready);
    p_occ_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= PTR_W'(DEPTH));
    p_no_ack_mid_instr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mid_m |-> !irq_ack);
    p_quiet_on_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (retire_cnt == 2'd0));
    p_quiet_after_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (retire_cnt == 2'd0));
    p_grant_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        uc_grant |=> !uc_grant);
    p_dev_blocks_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dev_m |-> !irq_ack);
endmodule

bind rob_irq_retire rob_irq_retire_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .occ(occ), .alloc_ready(alloc_ready),
    .retire_cnt(retire_cnt), .ret_last(ret_last), .flush(flush),
    .irq_ack(irq_ack), .uc_grant(uc_grant)
);

// File: tb/rob_irq_retire_test.sv
module rob_irq_retire_test;
    localparam int PERIOD = 10;
    localparam int DEPTH  = 8;
    localparam int PC_W   = 32;
    localparam int IDX_W  = $clog2(DEPTH);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             alloc_valid = 1'b0, alloc_first = 1'b0, alloc_last = 1'b0, alloc_uc = 1'b0;
    logic [PC_W-1:0]  alloc_pc = '0;
    logic             alloc_ready;
    logic [IDX_W-1:0] alloc_tag;
    logic             wb_valid = 1'b0;
    logic [IDX_W-1:0] wb_tag = '0;
    logic             uc_grant;
    logic [IDX_W-1:0] uc_grant_tag;
    logic [1:0]       retire_cnt;
    logic [IDX_W-1:0] ret_tag;
    logic             irq_req = 1'b0;
    logic             irq_ack;
    logic [PC_W-1:0]  front_pc = '0;
    logic             flush;
    logic [PC_W-1:0]  flush_pc;

    int n_cmp = 0;
    int n_bad = 0;
    int nxt_tag = 0;
    int exp_ret[$];
    int exp_flush[$];

    always #(PERIOD/2) clk = ~clk;

    rob_irq_retire #(.DEPTH(DEPTH), .PC_W(PC_W)) uut (.*);

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Start a new cycle with single-cycle strobes cleared.
    task automatic nc();
        @(negedge clk);
        alloc_valid = 1'b0;
        wb_valid    = 1'b0;
    endtask

    // Driver: allocate one micro-op and push its tag as an expected retirement.
    task automatic alloc(bit f, bit l, bit u, int pc);
        nc();
        alloc_valid = 1'b1; alloc_first = f; alloc_last = l; alloc_uc = u;
        alloc_pc = PC_W'(pc);
        #1;
        chk("R1 ready", int'(alloc_ready), 1);
        chk("R1 tag", int'(alloc_tag), nxt_tag);
        exp_ret.push_back(nxt_tag);
        nxt_tag = (nxt_tag + 1) % DEPTH;
    endtask

    task automatic wb(int t);
        nc();
        wb_valid = 1'b1;
        wb_tag = IDX_W'(t);
    endtask

    // Monitor: compare retirements and flushes against the scoreboard queues.
    always @(negedge clk) begin
        #3;
        if (rst_n) begin
            for (int i = 0; i < int'(retire_cnt); i++) begin
                n_cmp++;
                if (exp_ret.size() == 0) begin
                    n_bad++;
                    $display("FAIL R2 order: actual %0d expected none", (int'(ret_tag) + i) % DEPTH);
                end else begin
                    int e;
                    e = exp_ret.pop_front();
                    if ((int'(ret_tag) + i) % DEPTH != e) begin
                        n_bad++;
                        $display("FAIL R2 order: actual %0d expected %0d", (int'(ret_tag) + i) % DEPTH, e);
                    end
                end
            end
            if (flush) begin
                n_cmp++;
                if (exp_flush.size() == 0) begin
                    n_bad++;
                    $display("FAIL R5 flush: actual %0d expected none", flush_pc);
                end else begin
                    int e;
                    e = exp_flush.pop_front();
                    if (int'(flush_pc) != e || !irq_ack) begin
                        n_bad++;
                        $display("FAIL R5 flush_pc/ack: actual %0d/%0d expected %0d/1", flush_pc, irq_ack, e);
                    end
                end
                if (exp_ret.size() != 0) nxt_tag = exp_ret[0];
                exp_ret.delete();
            end
        end
    end

    initial begin
        #(PERIOD * 5000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        nc(); #1;
        // R10 reset state
        chk("R10 ready", int'(alloc_ready), 1);
        chk("R10 tag", int'(alloc_tag), 0);
        chk("R10 retire", int'(retire_cnt), 0);
        chk("R10 ack", int'(irq_ack | flush), 0);
        chk("R10 grant", int'(uc_grant), 0);

        // R2: out-of-order completion, in-order two-wide retirement
        alloc(1, 1, 0, 100);
        alloc(1, 1, 0, 104);
        alloc(1, 1, 0, 108);
        wb(1);
        wb(0); #1;
        chk("R2 stop at not-done head", int'(retire_cnt), 0);
        wb(2); #1;
        chk("R2 two per cycle", int'(retire_cnt), 2);
        nc(); #1;
        chk("R2 last single", int'(retire_cnt), 1);

        // R1: fill to DEPTH, then R5/R6 flush of a full buffer
        for (int i = 0; i < DEPTH; i++) alloc(1, 1, 0, 400 + 4 * i);
        nc(); alloc_valid = 1'b1; #1;
        chk("R1 full", int'(alloc_ready), 0);
        nc(); irq_req = 1'b1; exp_flush.push_back(400); #1;
        chk("R5 ack", int'(irq_ack), 1);
        chk("R5 flush_pc", int'(flush_pc), 400);
        chk("R6 no retire in flush", int'(retire_cnt), 0);
        nc(); irq_req = 1'b0; #1;
        chk("R6 ready again", int'(alloc_ready), 1);
        chk("R5 single pulse", int'(flush), 0);
        chk("R6 tag reuse", int'(alloc_tag), 3);
        wb(3);
        nc(); #1;
        chk("R6 stale wb ignored", int'(retire_cnt), 0);

        // R3/R4: split instruction A (3 uops at 200) then B (210)
        alloc(1, 0, 0, 200);
        alloc(0, 0, 0, 200);
        alloc(0, 1, 0, 200);
        alloc(1, 1, 0, 210);
        wb(3);
        nc(); #1;
        chk("R4 first uop retires", int'(retire_cnt), 1);
        nc(); irq_req = 1'b1; #1;
        chk("R3 no ack mid instr", int'(irq_ack), 0);
        wb(4); #1;
        chk("R3 no ack mid instr", int'(irq_ack), 0);
        nc(); #1;
        chk("R4 middle retires", int'(retire_cnt), 1);
        chk("R3 no ack mid instr", int'(irq_ack), 0);
        wb(5);
        nc(); #1;
        chk("R4 last retires", int'(retire_cnt), 1);
        chk("R4 no ack while closing", int'(irq_ack), 0);
        nc(); exp_flush.push_back(210); #1;
        chk("R4 ack at boundary", int'(irq_ack), 1);
        chk("R5 restart at next instr", int'(flush_pc), 210);
        nc(); irq_req = 1'b0;

        // R7/R8/R9: uncacheable access behind a normal micro-op
        alloc(1, 1, 0, 300);
        alloc(1, 1, 1, 304);
        wb(6); #1;
        chk("R7 no grant behind older", int'(uc_grant), 0);
        nc(); #1;
        chk("R7 no grant while older retires", int'(uc_grant), 0);
        nc(); #1;
        chk("R7 grant at head", int'(uc_grant), 1);
        chk("R7 grant tag", int'(uc_grant_tag), 7);
        nc(); irq_req = 1'b1; #1;
        chk("R7 grant pulse", int'(uc_grant), 0);
        chk("R8 blocked", int'(irq_ack), 0);
        wb(7); #1;
        chk("R8 blocked", int'(irq_ack), 0);
        nc(); #1;
        chk("R8 device retires", int'(retire_cnt), 1);
        chk("R8 blocked while retiring", int'(irq_ack), 0);
        nc(); front_pc = 500; exp_flush.push_back(500); #1;
        chk("R9 empty ack", int'(irq_ack), 1);
        chk("R9 front pc", int'(flush_pc), 500);
        nc(); irq_req = 1'b0;
        nc(); #4;
        chk("R5 all flushes seen", exp_flush.size(), 0);
        chk("R2 all retired or flushed", exp_ret.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule